// File: doc/BRIEF.md
# Two-Channel Bus Breakpoint Unit

This block watches the processor's bus cycles on two independent break channels. For each cycle a channel masks and compares the address and the data against programmed values. It also tests three qualifier groups: which bus carries the cycle, whether the cycle is an instruction fetch or a data access, and whether it reads or writes. When a channel matches, the block records the match in sticky flags. It raises a single break request toward the interrupt controller at a fixed priority of 15, and it fires a trigger pulse of programmable width on an output pin.

Software programs the unit through a write-only register port. The address is `{channel, index}`. Per-channel indices are 0 address compare, 1 address mask, 2 data compare, 3 data mask and 4 qualifier. Address 6 is the control register: bits [1:0] select the pulse width and bit 2 selects monitor-only mode. Address 7 clears flags. In monitor-only mode the pulse still fires and the flags still record matches, but no request goes out. Flags stay set until software clears them, so a request that is not serviced stays asserted.

Top module: `dual_bkpt_unit`

## Requirements
- R1: A channel's address test passes when `(bus_addr ^ compare) & ~mask` is zero; address bits set in the address mask are ignored.
- R2: A channel's data test passes when `(bus_data ^ compare) & ~mask` is zero; data bits set in the data mask are ignored.
- R3: The qualifier register holds bus select in bits [1:0] (bit0 = C bus, bit1 = I bus), access kind in bits [3:2] (bit2 = fetch, bit3 = data) and direction in bits [5:4] (bit4 = read, bit5 = write). A cycle matches only if its bus, kind and direction bits are set. If any group is 00, the channel never matches.
- R4: A match sets flag bit 2*ch when `bus_ibus`=0 (C bus) or bit 2*ch+1 when `bus_ibus`=1 (I bus). The flag is visible on `flag_o` one clock after the matching cycle, and a simultaneous match on both channels sets both channels' flags.
- R5: Flags are sticky. A write to address 7 clears each flag whose bit in write data [3:0] is 0 and leaves each flag whose bit is 1. A match in the same cycle as the clear wins and keeps its flag set.
- R6: `brk_req_o` is 1 whenever any flag is set and monitor-only is 0. Matches on both channels give one request line, not two.
- R7: With monitor-only set, `brk_req_o` stays 0 while flags and the trigger pulse still work.
- R8: A match starts a pulse on `trig_o` in the next cycle, lasting 1, 2, 4 or 8 cycles for width select 0 to 3. A new match during a pulse restarts the full width.
- R9: `brk_level_o` is always 15.
- R10: After reset all registers are zero, so every channel is disabled and flags, `brk_req_o` and `trig_o` are 0.
- R11: A register write takes effect on the clock edge that ends the write cycle. A bus cycle in that same cycle is compared against the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address {channel, index} |
| reg_wdata | input | 32 | Register write data |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_ibus | input | 1 | 1 = cycle on I bus, 0 = C bus |
| bus_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Bus cycle address |
| bus_data | input | 32 | Bus cycle data |
| brk_req_o | output | 1 | Combined break request |
| brk_level_o | output | 4 | Priority of the request (15) |
| trig_o | output | 1 | Trigger pulse output |
| flag_o | output | 4 | Match flags {ch1 I, ch1 C, ch0 I, ch0 C} |

## Verification
Flags and the start of the trigger pulse are due exactly one clock after the bus cycle that matches. The request follows the flags and the monitor-only bit in that same later cycle. A register write changes behaviour only from the following cycle. The bench updates its behavioural model on each rising edge from the inputs it drove half a period earlier. It compares every output against that model at the falling edge, so each result is checked in the cycle it is due and in no other.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
    localparam int unsigned ADDR_W    = 32;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned N_CH      = 2;
    localparam int unsigned RADDR_W   = 4;
    localparam int unsigned IDX_W     = 3;
    localparam int unsigned CH_SEL_W  = RADDR_W - IDX_W;
    localparam int unsigned WSEL_W    = 2;
    localparam int unsigned FLAG_W    = 2 * N_CH;
    localparam int unsigned QUAL_W    = 6;
    localparam int unsigned MAX_PULSE = 1 << ((1 << WSEL_W) - 1);
    localparam int unsigned CNT_W     = $clog2(MAX_PULSE + 1);
    localparam logic [3:0]  BRK_LEVEL = 4'd15;

    typedef struct packed {
        logic [1:0] dir;   // bit0 read, bit1 write
        logic [1:0] kind;  // bit0 fetch, bit1 data
        logic [1:0] bus;   // bit0 C bus, bit1 I bus
    } qual_t;

    typedef struct packed {
        logic [ADDR_W-1:0] acmp;
        logic [ADDR_W-1:0] amask;
        logic [DATA_W-1:0] dcmp;
        logic [DATA_W-1:0] dmask;
        qual_t             qual;
    } chan_cfg_t;

    typedef struct packed {
        chan_cfg_t [N_CH-1:0] ch;
        logic [WSEL_W-1:0]    wsel;
        logic                 mon;
        logic [FLAG_W-1:0]    flag;
    } unit_state_t;

    typedef enum logic [IDX_W-1:0] {
        IDX_ACMP  = 3'd0,
        IDX_AMASK = 3'd1,
        IDX_DCMP  = 3'd2,
        IDX_DMASK = 3'd3,
        IDX_QUAL  = 3'd4,
        IDX_CTRL  = 3'd6,
        IDX_CLR   = 3'd7
    } reg_idx_e;

    localparam logic [RADDR_W-1:0] CTRL_ADDR = RADDR_W'(IDX_CTRL);
    localparam logic [RADDR_W-1:0] CLR_ADDR  = RADDR_W'(IDX_CLR);
endpackage

// File: rtl/bkpt_match.sv
module bkpt_match
    import bkpt_pkg::*;
(
    input  chan_cfg_t         cfg_i,
    input  logic              valid_i,
    input  logic              ibus_i,
    input  logic              fetch_i,
    input  logic              write_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              hit_o
);
    logic addr_ok, data_ok, armed, bus_ok, kind_ok, dir_ok;

    always_comb begin
        addr_ok = ((addr_i ^ cfg_i.acmp) & ~cfg_i.amask) == '0;
        data_ok = ((data_i ^ cfg_i.dcmp) & ~cfg_i.dmask) == '0;
        armed   = (cfg_i.qual.bus != 2'b00) && (cfg_i.qual.kind != 2'b00)
                  && (cfg_i.qual.dir != 2'b00);
        bus_ok  = ibus_i  ? cfg_i.qual.bus[1]  : cfg_i.qual.bus[0];
        kind_ok = fetch_i ? cfg_i.qual.kind[0] : cfg_i.qual.kind[1];
        dir_ok  = write_i ? cfg_i.qual.dir[1]  : cfg_i.qual.dir[0];
        hit_o   = valid_i && armed && addr_ok && data_ok && bus_ok && kind_ok && dir_ok;
    end
endmodule

// File: rtl/bkpt_pulse.sv
module bkpt_pulse
    import bkpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WSEL_W-1:0] wsel_i,
    output logic              active_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = CNT_W'(1) << wsel_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign active_o = (cnt_q != '0);
endmodule

// File: rtl/dual_bkpt_unit.sv
module dual_bkpt_unit
    import bkpt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [RADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    input  logic               bus_valid,
    input  logic               bus_ibus,
    input  logic               bus_fetch,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_data,
    output logic               brk_req_o,
    output logic [3:0]         brk_level_o,
    output logic               trig_o,
    output logic [FLAG_W-1:0]  flag_o
);
    unit_state_t                   st_d, st_q;
    logic [N_CH-1:0]               hit;
    logic [N_CH-1:0][QUAL_W-1:0]   qual_vec;
    logic [FLAG_W-1:0]             set_vec;
    logic [FLAG_W-1:0]             clr_keep;
    reg_idx_e                      idx;

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        bkpt_match u_match (
            .cfg_i   (st_q.ch[g]),
            .valid_i (bus_valid),
            .ibus_i  (bus_ibus),
            .fetch_i (bus_fetch),
            .write_i (bus_write),
            .addr_i  (bus_addr),
            .data_i  (bus_data),
            .hit_o   (hit[g])
        );
        assign qual_vec[g] = st_q.ch[g].qual;
    end

    always_comb begin
        st_d     = st_q;
        clr_keep = '1;
        set_vec  = '0;
        idx      = reg_idx_e'(reg_addr[IDX_W-1:0]);
        if (reg_we) begin
            if (reg_addr == CTRL_ADDR) begin
                st_d.wsel = reg_wdata[WSEL_W-1:0];
                st_d.mon  = reg_wdata[WSEL_W];
            end
            if (reg_addr == CLR_ADDR) begin
                clr_keep = reg_wdata[FLAG_W-1:0];
            end
            for (int c = 0; c < N_CH; c++) begin
                if (reg_addr[RADDR_W-1 -: CH_SEL_W] == CH_SEL_W'(c)) begin
                    case (idx)
                        IDX_ACMP:  st_d.ch[c].acmp  = reg_wdata[ADDR_W-1:0];
                        IDX_AMASK: st_d.ch[c].amask = reg_wdata[ADDR_W-1:0];
                        IDX_DCMP:  st_d.ch[c].dcmp  = reg_wdata;
                        IDX_DMASK: st_d.ch[c].dmask = reg_wdata;
                        IDX_QUAL:  st_d.ch[c].qual  = qual_t'(reg_wdata[QUAL_W-1:0]);
                        default: ;
                    endcase
                end
            end
        end
        for (int c = 0; c < N_CH; c++) begin
            set_vec[2*c]   = hit[c] & ~bus_ibus;
            set_vec[2*c+1] = hit[c] &  bus_ibus;
        end
        st_d.flag = (st_q.flag & clr_keep) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    bkpt_pulse u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (|hit),
        .wsel_i   (st_q.wsel),
        .active_o (trig_o)
    );

    assign flag_o      = st_q.flag;
    assign brk_req_o   = (|st_q.flag) & ~st_q.mon;
    assign brk_level_o = BRK_LEVEL;
endmodule

// File: rtl/bkpt_chk.sv
module bkpt_chk
    import bkpt_pkg::*;
(
    input logic                        clk,
    input logic                        rst_n,
    input logic                        reg_we,
    input logic [RADDR_W-1:0]          reg_addr,
    input logic [N_CH-1:0]             hit,
    input logic [N_CH-1:0][QUAL_W-1:0] quals,
    input logic [FLAG_W-1:0]           flag,
    input logic                        brk_req,
    input logic                        mon,
    input logic                        trig
);
    logic clr_wr;
    assign clr_wr = reg_we && (reg_addr == CLR_ADDR);

    for (genvar g = 0; g < N_CH; g++) begin : g_q
        p_zero_group_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (quals[g][1:0] == 2'b00 || quals[g][3:2] == 2'b00 || quals[g][5:4] == 2'b00)
            |-> !hit[g]);
    end

    p_flags_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((flag & $past(flag)) == $past(flag)));

    p_new_flag_needs_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(|hit) |=> ((flag & ~$past(flag)) == '0));

    p_hit_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> (flag != '0));

    p_mon_blocks_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mon |-> !brk_req);

    p_hit_fires_trig_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> trig);
endmodule

bind dual_bkpt_unit bkpt_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .hit      (hit),
    .quals    (qual_vec),
    .flag     (flag_o),
    .brk_req  (brk_req_o),
    .mon      (st_q.mon),
    .trig     (trig_o)
);

// File: tb/dual_bkpt_unit_tb.sv
module dual_bkpt_unit_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        reg_we = 0;
    logic [3:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic        bus_valid = 0, bus_ibus = 0, bus_fetch = 0, bus_write = 0;
    logic [31:0] bus_addr = 0, bus_data = 0;
    logic        brk_req_o, trig_o;
    logic [3:0]  brk_level_o, flag_o;

    always #4 clk = ~clk;

    dual_bkpt_unit u_dut (.*);

    // behavioural reference model
    logic [31:0] m_acmp[2], m_amask[2], m_dcmp[2], m_dmask[2];
    logic [5:0]  m_qual[2];
    int          m_wsel, m_cnt;
    bit          m_mon;
    logic [3:0]  m_flag;

    int    n_cmp = 0, n_bad = 0;
    string cur_req = "R10";
    bit    cmp_on = 0;

    function automatic bit mdl_hit(int c);
        if (!bus_valid) return 0;
        if ((bus_addr & ~m_amask[c]) != (m_acmp[c] & ~m_amask[c])) return 0;
        if ((bus_data & ~m_dmask[c]) != (m_dcmp[c] & ~m_dmask[c])) return 0;
        if (!m_qual[c][bus_ibus ? 1 : 0])  return 0;
        if (!m_qual[c][bus_fetch ? 2 : 3]) return 0;
        if (!m_qual[c][bus_write ? 5 : 4]) return 0;
        return 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_acmp[c] = 0; m_amask[c] = 0; m_dcmp[c] = 0; m_dmask[c] = 0; m_qual[c] = 0;
            end
            m_wsel = 0; m_cnt = 0; m_mon = 0; m_flag = 0;
        end else begin
            bit h0, h1;
            logic [3:0] keep;
            h0 = mdl_hit(0);
            h1 = mdl_hit(1);
            keep = (reg_we && reg_addr == 4'd7) ? reg_wdata[3:0] : 4'hF;
            m_flag = m_flag & keep;
            if (h0) m_flag[bus_ibus ? 1 : 0] = 1'b1;
            if (h1) m_flag[bus_ibus ? 3 : 2] = 1'b1;
            if (h0 || h1)      m_cnt = 1 << m_wsel;
            else if (m_cnt > 0) m_cnt = m_cnt - 1;
            if (reg_we) begin
                int c;
                c = reg_addr[3];
                case (reg_addr[2:0])
                    3'd0: m_acmp[c]  = reg_wdata;
                    3'd1: m_amask[c] = reg_wdata;
                    3'd2: m_dcmp[c]  = reg_wdata;
                    3'd3: m_dmask[c] = reg_wdata;
                    3'd4: m_qual[c]  = reg_wdata[5:0];
                    3'd6: if (c == 0) begin m_wsel = reg_wdata[1:0]; m_mon = reg_wdata[2]; end
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk(cur_req, "flag_o", flag_o, m_flag);
            chk(cur_req, "brk_req_o", brk_req_o, (m_flag != 0) && !m_mon);
            chk(cur_req, "trig_o", trig_o, m_cnt != 0);
            chk("R9", "brk_level_o", brk_level_o, 15);
        end
    end

    task automatic idle_inputs();
        reg_we = 0; reg_addr = 0; reg_wdata = 0;
        bus_valid = 0; bus_ibus = 0; bus_fetch = 0; bus_write = 0; bus_addr = 0; bus_data = 0;
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic bus(bit ib, bit f, bit w, logic [31:0] a, logic [31:0] d);
        bus_valid = 1; bus_ibus = ib; bus_fetch = f; bus_write = w; bus_addr = a; bus_data = d;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10: reset state at the ports
        chk("R10", "flag_o reset", flag_o, 0);
        chk("R10", "brk_req_o reset", brk_req_o, 0);
        chk("R10", "trig_o reset", trig_o, 0);
        chk("R9", "brk_level_o", brk_level_o, 15);
        cmp_on = 1;
        // R10/R3: all qualifiers zero after reset, nothing can match
        bus(0, 0, 0, 0, 0);
        idle(2);
        // R1: address mask, ch0 any bus/kind/dir
        cur_req = "R1";
        wr(4'h0, 32'h0000_1000);
        wr(4'h1, 32'h0000_000F);
        wr(4'h3, 32'hFFFF_FFFF);
        wr(4'h4, 32'h0000_003F);
        bus(0, 0, 0, 32'h0000_1005, 32'h1234);
        idle(2);
        bus(0, 0, 0, 32'h0000_1015, 32'h1234);
        idle(1);
        // R5: clear selected flags, keep others; set wins over clear
        cur_req = "R5";
        wr(4'h7, 32'h0000_000E);
        idle(1);
        bus(1, 1, 0, 32'h0000_1003, 0);
        reg_we = 1; reg_addr = 4'h7; reg_wdata = 0;
        bus(0, 0, 1, 32'h0000_1004, 0);
        idle(1);
        wr(4'h7, 0);
        // R2: data mask on ch1, I-bus flag position (R4)
        cur_req = "R2";
        wr(4'h9, 32'hFFFF_FFFF);
        wr(4'hA, 32'h0000_00A5);
        wr(4'hB, 32'hFFFF_FF00);
        wr(4'hC, 32'h0000_003F);
        bus(1, 0, 1, 32'hDEAD_0000, 32'h1234_56A5);
        idle(1);
        bus(1, 0, 1, 32'hDEAD_0000, 32'h1234_56A4);
        wr(4'h7, 0);
        // R3: qualifier groups
        cur_req = "R3";
        wr(4'h4, 32'h0000_0035);   // C bus, fetch only, read+write
        bus(0, 0, 0, 32'h0000_1000, 0);   // data access: no hit
        bus(1, 1, 0, 32'h0000_1000, 0);   // I bus: no hit
        bus(0, 1, 1, 32'h0000_1000, 0);   // hit
        wr(4'h7, 0);
        wr(4'h4, 32'h0000_0019);   // C bus, data, read only
        bus(0, 0, 1, 32'h0000_1000, 0);   // write: no hit
        bus(0, 0, 0, 32'h0000_1000, 0);   // hit
        wr(4'h7, 0);
        wr(4'h4, 32'h0000_000F);   // direction group 00: disabled
        bus(0, 0, 0, 32'h0000_1000, 0);
        bus(0, 1, 1, 32'h0000_1000, 0);
        wr(4'h4, 32'h0000_0033);   // kind group 00: disabled
        bus(0, 0, 0, 32'h0000_1000, 0);
        idle(2);
        // R6/R4: both channels at once, one request line
        cur_req = "R6";
        wr(4'h4, 32'h0000_003F);
        bus(0, 0, 0, 32'h0000_1000, 32'h0000_00A5);
        idle(2);
        bus(1, 0, 0, 32'h0000_1001, 32'h0000_00A5);
        idle(2);
        wr(4'h7, 0);
        // R8: pulse widths and restart
        cur_req = "R8";
        for (int w = 0; w < 4; w++) begin
            wr(4'h6, w);
            bus(0, 0, 0, 32'h0000_1000, 0);
            idle(10);
        end
        bus(0, 0, 0, 32'h0000_1000, 0);
        idle(3);
        bus(0, 0, 0, 32'h0000_1000, 0);
        idle(10);
        wr(4'h7, 0);
        // R7: monitor-only
        cur_req = "R7";
        wr(4'h6, 32'h0000_0005);
        bus(0, 0, 0, 32'h0000_1000, 0);
        idle(4);
        wr(4'h6, 32'h0000_0001);   // request appears from held flag
        idle(2);
        wr(4'h7, 0);
        // R11: write and bus cycle in the same clock
        cur_req = "R11";
        reg_we = 1; reg_addr = 4'h0; reg_wdata = 32'h0000_2000;
        bus(0, 0, 0, 32'h0000_2000, 0);
        idle(1);
        bus(0, 0, 0, 32'h0000_2000, 0);
        idle(2);
        wr(4'h7, 0);
        // R4: mixed random traffic
        cur_req = "R4";
        for (int i = 0; i < 600; i++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[3:0] == 0) begin
                reg_we = 1; reg_addr = r[7:4];
                reg_wdata = (r[7:4] == 4'h4 || r[7:4] == 4'hC) ? {26'h0, r[13:8]} :
                            (r[6:4] == 3'd1 || r[6:4] == 3'd3) ? {28'h0, r[11:8]} :
                            {24'h0, r[15:8]};
            end
            if (r[16]) begin
                bus_valid = 1; bus_ibus = r[17]; bus_fetch = r[18]; bus_write = r[19];
                bus_addr = {24'h0000_00, r[27:20]};
                bus_data = {28'h0, r[31:28]};
            end
            @(negedge clk);
            idle_inputs();
        end
        idle(12);
        finish_run();
    end
endmodule